// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses which of two oscillators clocks the device: an external-crystal style primary oscillator or an internal RC oscillator. Software drives a 2-bit source select. The value 2'b11 asks for the internal RC clock. Every other value asks for the primary clock. The controller itself runs on the RC clock.

When the primary clock is requested, the controller enables the primary oscillator and keeps the device on the RC clock. Meanwhile a start-up timer in the primary domain counts a fixed number of primary periods. When the timer's synchronized done signal arrives, the controller moves the clock multiplexer to the primary clock with a break-before-make handshake. It raises a status flag only after the primary branch of the multiplexer is confirmed open. Going back to the RC clock reverses this: the flag drops, the multiplexer hands over to the RC branch, and only then is the primary oscillator switched off.

The RC oscillator enable stays high whenever the watchdog or the fail-safe monitor needs that clock, and whenever the controller still depends on it.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is held and after it is released, `pri_active` and `mux_sel_pri` read 0 and `sys_clk` is taken from `clk_rc`; with `src_sel` at 2'b11, `pri_osc_en` stays 0.
- R2: `src_sel` value 2'b11 selects the RC clock and keeps `pri_osc_en` at 0; values 2'b00, 2'b01 and 2'b10 all select the primary clock and raise `pri_osc_en`.
- R3: `pri_active` rises only after at least OST_CYCLES (default 1024) rising edges of `clk_pri` have occurred since `pri_osc_en` rose, and no later than OST_CYCLES+40 such edges.
- R4: While the primary oscillator is starting up, `sys_clk` keeps following `clk_rc` and `pri_active` stays 0.
- R5: Once `pri_active` is 1, `sys_clk` follows `clk_pri`, `mux_sel_pri` is 1 and `pri_osc_en` is 1.
- R6: When `src_sel` becomes 2'b11 while running on the primary clock, `pri_active` clears on the next `clk_rc` edge; `sys_clk` returns to `clk_rc`; `pri_osc_en` falls only after the RC branch of the multiplexer is open.
- R7: When `src_sel` becomes 2'b11 during start-up, `pri_osc_en` drops on the next `clk_rc` edge and `pri_active` never rises; a later primary request restarts the full OST_CYCLES count.
- R8: `rc_osc_en` is 0 only when running on the primary clock with `wdt_en`=0, `fsm_en`=0 and `src_sel` not 2'b11; otherwise it is 1.
- R9: Every high phase and every low phase of `sys_clk` lasts at least the shorter half period of the two source clocks.
- R10: The two multiplexer branch enables are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock |
| clk_rc | input | 1 | Internal RC oscillator clock; the controller runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select; 2'b11 means RC, any other value means primary |
| wdt_en | input | 1 | Watchdog enabled; keeps the RC oscillator on |
| fsm_en | input | 1 | Fail-safe monitor enabled; keeps the RC oscillator on |
| sys_clk | output | 1 | Glitch-free multiplexed device clock |
| mux_sel_pri | output | 1 | Multiplexer select request toward the primary branch |
| pri_osc_en | output | 1 | Primary oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| pri_active | output | 1 | Status: the primary clock is driving the device |

## Verification
The bench walks every select value from the RC state. For each one it counts primary edges from oscillator enable to the status flag. A timer that is too short, or a status flag raised before the multiplexer changed over, shows up as a count below 1024. A missing switch shows up as a timeout. The bench cancels a start-up midway and then asks for the primary clock again. This catches a timer that does not reset, which would hand over after only the remaining count, and an abort that leaves the oscillator enabled. It also sweeps the watchdog and fail-safe enables while on the primary clock, which catches a wrongly decoded RC enable. A pulse-width monitor on `sys_clk` catches a multiplexer that switches mid-phase and emits a runt pulse.

// File: rtl/css_pkg.sv
package css_pkg;

  typedef enum logic [2:0] {
    CSS_ON_RC  = 3'd0,
    CSS_START  = 3'd1,
    CSS_SWITCH = 3'd2,
    CSS_ON_PRI = 3'd3,
    CSS_TO_RC  = 3'd4
  } css_state_e;

  localparam logic [1:0] CSS_SEL_RC = 2'b11;

endpackage

// File: rtl/css_rst_sync.sv
module css_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = shift_q[STAGES-1];

endmodule

// File: rtl/css_bit_sync.sv
module css_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], d};
    end
  end

  assign q = shift_q[STAGES-1];

endmodule

// File: rtl/css_ost_timer.sv
module css_ost_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  // counting stops once the limit is reached
  assign cnt_en = !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      if (cnt_q == LAST) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/css_clk_gate.sv
module css_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic gclk
);

  logic meta_q;
  logic en_q;

  // first stage on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
    end else begin
      meta_q <= req;
    end
  end

  // enable changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= meta_q;
    end
  end

  assign en   = en_q;
  assign gclk = clk & en_q;

endmodule

// File: rtl/css_fsm.sv
module css_fsm
  import css_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       wdt_en,
  input  logic       fsm_en,
  input  logic       ost_done,
  input  logic       pri_ack,
  input  logic       rc_ack,
  output css_state_e state_o,
  output logic       mux_sel_pri,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       pri_active
);

  css_state_e state_q, state_d;
  logic       sel_rc;
  logic       upd;
  logic       mux_q, mux_d;
  logic       posc_q, posc_d;
  logic       act_q, act_d;
  logic       rc_need_q, rc_need_d;

  assign sel_rc = (src_sel == CSS_SEL_RC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CSS_ON_RC:  if (!sel_rc && !ost_done) state_d = CSS_START;
      CSS_START: begin
        if (sel_rc)        state_d = CSS_ON_RC;
        else if (ost_done) state_d = CSS_SWITCH;
      end
      CSS_SWITCH: if (pri_ack) state_d = CSS_ON_PRI;
      CSS_ON_PRI: if (sel_rc) state_d = CSS_TO_RC;
      CSS_TO_RC:  if (rc_ack && !pri_ack) state_d = CSS_ON_RC;
      default:    state_d = CSS_ON_RC;
    endcase
  end

  // registered outputs decoded from the next state
  always_comb begin
    posc_d    = (state_d != CSS_ON_RC);
    mux_d     = (state_d == CSS_SWITCH) || (state_d == CSS_ON_PRI);
    act_d     = (state_d == CSS_ON_PRI);
    rc_need_d = (state_d != CSS_ON_PRI);
  end

  assign upd = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CSS_ON_RC;
      mux_q     <= 1'b0;
      posc_q    <= 1'b0;
      act_q     <= 1'b0;
      rc_need_q <= 1'b1;
    end else if (upd) begin
      state_q   <= state_d;
      mux_q     <= mux_d;
      posc_q    <= posc_d;
      act_q     <= act_d;
      rc_need_q <= rc_need_d;
    end
  end

  assign state_o     = state_q;
  assign mux_sel_pri = mux_q;
  assign pri_osc_en  = posc_q;
  assign pri_active  = act_q;
  // the select term wakes a stopped RC oscillator without a clock
  assign rc_osc_en   = rc_need_q | wdt_en | fsm_en | sel_rc;

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import css_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_pri,
  input  logic       clk_rc,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       wdt_en,
  input  logic       fsm_en,
  output logic       sys_clk,
  output logic       mux_sel_pri,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       pri_active
);

  logic       rst_rc_n;
  logic       rst_pri_n;
  logic       rst_ost_n;
  logic       ost_arst_n;
  logic       ost_done_raw;
  logic       ost_done_s;
  logic       pri_gate_en;
  logic       rc_gate_en;
  logic       pri_ack;
  logic       pri_req;
  logic       rc_req;
  logic       gclk_pri;
  logic       gclk_rc;
  css_state_e state;

  css_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_rc (
    .clk(clk_rc), .arst_n(rst_n), .rst_n_o(rst_rc_n));

  css_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_pri (
    .clk(clk_pri), .arst_n(rst_n), .rst_n_o(rst_pri_n));

  // start-up timer is held cleared whenever the oscillator is off
  assign ost_arst_n = rst_n & pri_osc_en;

  css_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ost (
    .clk(clk_pri), .arst_n(ost_arst_n), .rst_n_o(rst_ost_n));

  css_ost_timer #(.CYCLES(OST_CYCLES)) u_ost (
    .clk(clk_pri), .rst_n(rst_ost_n), .done(ost_done_raw));

  css_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk_rc), .rst_n(rst_rc_n), .d(ost_done_raw), .q(ost_done_s));

  css_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk_rc), .rst_n(rst_rc_n), .d(pri_gate_en), .q(pri_ack));

  css_fsm u_fsm (
    .clk        (clk_rc),
    .rst_n      (rst_rc_n),
    .src_sel    (src_sel),
    .wdt_en     (wdt_en),
    .fsm_en     (fsm_en),
    .ost_done   (ost_done_s),
    .pri_ack    (pri_ack),
    .rc_ack     (rc_gate_en),
    .state_o    (state),
    .mux_sel_pri(mux_sel_pri),
    .pri_osc_en (pri_osc_en),
    .rc_osc_en  (rc_osc_en),
    .pri_active (pri_active)
  );

  // break-before-make: each branch waits for the other to close
  assign pri_req = mux_sel_pri & ~rc_gate_en;
  assign rc_req  = ~mux_sel_pri & ~pri_gate_en;

  css_clk_gate u_gate_pri (
    .clk(clk_pri), .rst_n(rst_pri_n), .req(pri_req),
    .en(pri_gate_en), .gclk(gclk_pri));

  css_clk_gate u_gate_rc (
    .clk(clk_rc), .rst_n(rst_rc_n), .req(rc_req),
    .en(rc_gate_en), .gclk(gclk_rc));

  assign sys_clk = gclk_pri | gclk_rc;

endmodule

// File: rtl/css_checker.sv
module css_checker
  import css_pkg::*;
(
  input logic       clk_rc,
  input logic       rst_rc_n,
  input logic [1:0] src_sel,
  input logic       wdt_en,
  input logic       fsm_en,
  input logic       mux_sel_pri,
  input logic       pri_osc_en,
  input logic       rc_osc_en,
  input logic       pri_active,
  input logic       pri_gate_en,
  input logic       rc_gate_en,
  input logic       pri_ack,
  input logic       ost_done_s,
  input css_state_e state
);

  assert_gates_exclusive_R10: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    !(pri_gate_en && rc_gate_en));

  assert_sel_rc_hold_R2: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    (state == CSS_ON_RC && src_sel == 2'b11) |=> !pri_osc_en);

  assert_switch_after_ost_R3: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    $rose(mux_sel_pri) |-> ost_done_s);

  assert_active_on_pri_R5: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    pri_active |-> (pri_ack && mux_sel_pri && pri_osc_en));

  assert_pri_off_after_rc_R6: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    $fell(pri_osc_en) |-> rc_gate_en);

  assert_abort_start_R7: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    (state == CSS_START && src_sel == 2'b11) |=> (!pri_osc_en && !pri_active));

  assert_rc_keep_R8: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    (wdt_en || fsm_en || src_sel == 2'b11) |-> rc_osc_en);

  assert_rc_drop_R8: assert property (@(posedge clk_rc) disable iff (!rst_rc_n)
    (pri_active && !wdt_en && !fsm_en && src_sel != 2'b11) |-> !rc_osc_en);

endmodule

bind clk_src_switch css_checker u_css_checker (
  .clk_rc     (clk_rc),
  .rst_rc_n   (rst_rc_n),
  .src_sel    (src_sel),
  .wdt_en     (wdt_en),
  .fsm_en     (fsm_en),
  .mux_sel_pri(mux_sel_pri),
  .pri_osc_en (pri_osc_en),
  .rc_osc_en  (rc_osc_en),
  .pri_active (pri_active),
  .pri_gate_en(pri_gate_en),
  .rc_gate_en (rc_gate_en),
  .pri_ack    (pri_ack),
  .ost_done_s (ost_done_s),
  .state      (state)
);

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;

  localparam int  CLK_PERIOD = 10;
  localparam int  PRI_HALF   = 3;
  localparam int  OST        = 1024;
  localparam real MIN_W      = PRI_HALF - 0.01;

  logic       clk_pri = 1'b0;
  logic       clk_rc  = 1'b0;
  logic       rst_n;
  logic [1:0] src_sel;
  logic       wdt_en;
  logic       fsm_en;
  logic       sys_clk;
  logic       mux_sel_pri;
  logic       pri_osc_en;
  logic       rc_osc_en;
  logic       pri_active;

  int checks   = 0;
  int failures = 0;
  int pri_edges = 0;
  int rc_edges  = 0;
  int sys_edges = 0;
  int glitches  = 0;
  bit mon_on    = 1'b0;
  bit mon_armed = 1'b0;
  bit seen_active = 1'b0;
  real last_t;

  clk_src_switch i_clk_src_switch (
    .clk_pri(clk_pri), .clk_rc(clk_rc), .rst_n(rst_n),
    .src_sel(src_sel), .wdt_en(wdt_en), .fsm_en(fsm_en),
    .sys_clk(sys_clk), .mux_sel_pri(mux_sel_pri),
    .pri_osc_en(pri_osc_en), .rc_osc_en(rc_osc_en),
    .pri_active(pri_active));

  initial forever #(CLK_PERIOD/2) clk_rc = ~clk_rc;

  // primary oscillator model: runs only while enabled
  initial forever begin
    #(PRI_HALF);
    if (pri_osc_en === 1'b1) clk_pri = ~clk_pri;
    else                     clk_pri = 1'b0;
  end

  always @(posedge clk_pri) pri_edges++;
  always @(posedge clk_rc)  rc_edges++;
  always @(posedge sys_clk) sys_edges++;
  always @(posedge pri_active) seen_active = 1'b1;

  // R9 pulse-width monitor
  always @(sys_clk) begin
    if (mon_on) begin
      if (mon_armed && ($realtime - last_t) < MIN_W) glitches++;
      mon_armed = 1'b1;
      last_t = $realtime;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_rc);
    #1;
  endtask

  task automatic follows(input bit want_pri, input string tag);
    int s0, r0, p0, ds, dr;
    s0 = sys_edges; r0 = rc_edges; p0 = pri_edges;
    cycles(20);
    ds = sys_edges - s0;
    dr = want_pri ? (pri_edges - p0) : (rc_edges - r0);
    chk(ds >= dr - 1 && ds <= dr + 1, tag, ds, dr);
  endtask

  // request primary with a given select and measure the start-up count
  task automatic go_primary(input logic [1:0] sel, input string tag);
    int p0, n, guard;
    @(negedge clk_rc);
    src_sel = sel;
    guard = 0;
    while (pri_osc_en !== 1'b1 && guard < 20) begin cycles(1); guard++; end
    chk(pri_osc_en === 1'b1, {tag, " R2 pri_osc_en raised"}, int'(pri_osc_en), 1);
    p0 = pri_edges;
    follows(1'b0, {tag, " R4 sys_clk on rc during start-up"});
    chk(pri_active === 1'b0, {tag, " R4 status low during start-up"}, int'(pri_active), 0);
    guard = 0;
    while (pri_active !== 1'b1 && guard < 2000) begin cycles(1); guard++; end
    n = pri_edges - p0;
    chk(pri_active === 1'b1, {tag, " R3 status set"}, int'(pri_active), 1);
    chk(n >= OST, {tag, " R3 not before timer"}, n, OST);
    chk(n <= OST + 40, {tag, " R3 bounded latency"}, n, OST + 40);
    chk(mux_sel_pri === 1'b1 && pri_osc_en === 1'b1, {tag, " R5 select and enable"},
        int'(mux_sel_pri), 1);
    follows(1'b1, {tag, " R5 sys_clk on primary"});
  endtask

  task automatic go_rc(input string tag);
    int guard;
    @(negedge clk_rc);
    src_sel = 2'b11;
    cycles(1);
    chk(pri_active === 1'b0, {tag, " R6 status cleared next edge"}, int'(pri_active), 0);
    chk(rc_osc_en === 1'b1, {tag, " R8 rc on when select is rc"}, int'(rc_osc_en), 1);
    guard = 0;
    while (pri_osc_en !== 1'b0 && guard < 60) begin cycles(1); guard++; end
    chk(pri_osc_en === 1'b0, {tag, " R6 primary disabled"}, int'(pri_osc_en), 0);
    follows(1'b0, {tag, " R6 sys_clk back on rc"});
  endtask

  initial begin
    rst_n = 1'b0; src_sel = 2'b11; wdt_en = 1'b0; fsm_en = 1'b0;
    cycles(4);
    chk(pri_active === 1'b0 && mux_sel_pri === 1'b0, "R1 outputs in reset",
        int'({pri_active, mux_sel_pri}), 0);
    @(negedge clk_rc); rst_n = 1'b1;
    cycles(6);
    mon_on = 1'b1;
    chk(pri_active === 1'b0, "R1 status after reset", int'(pri_active), 0);
    chk(mux_sel_pri === 1'b0, "R1 mux on rc after reset", int'(mux_sel_pri), 0);
    chk(pri_osc_en === 1'b0, "R2 select 11 keeps primary off", int'(pri_osc_en), 0);
    chk(rc_osc_en === 1'b1, "R8 rc on in rc state", int'(rc_osc_en), 1);
    follows(1'b0, "R1 sys_clk follows rc");

    // every primary select value, each followed by the rc sweep and return
    for (int s = 0; s < 3; s++) begin
      go_primary(2'(s), $sformatf("sel=%0d", s));
      for (int c = 0; c < 4; c++) begin
        @(negedge clk_rc);
        wdt_en = c[0]; fsm_en = c[1];
        #1;
        chk(rc_osc_en === (c[0] | c[1]), $sformatf("R8 rc enable wdt=%0d fsm=%0d", c[0], c[1]),
            int'(rc_osc_en), int'(c[0] | c[1]));
      end
      @(negedge clk_rc); wdt_en = 1'b0; fsm_en = 1'b0;
      go_rc($sformatf("sel=%0d", s));
      cycles(10);
      chk(pri_osc_en === 1'b0, "R2 stays on rc while select is 11", int'(pri_osc_en), 0);
    end

    // R7: abort mid-count, then a full restart
    @(negedge clk_rc); src_sel = 2'b00;
    cycles(150);
    chk(pri_osc_en === 1'b1 && pri_active === 1'b0, "R7 mid-count state",
        int'({pri_osc_en, pri_active}), 2);
    seen_active = 1'b0;
    @(negedge clk_rc); src_sel = 2'b11;
    cycles(1);
    chk(pri_osc_en === 1'b0, "R7 abort drops primary enable", int'(pri_osc_en), 0);
    cycles(20);
    chk(seen_active == 1'b0, "R7 status never rose", int'(seen_active), 0);
    follows(1'b0, "R7 sys_clk stays on rc");
    go_primary(2'b10, "R7 restart");
    go_rc("final");

    cycles(5);
    chk(glitches == 0, "R9 R10 no runt sys_clk phase", glitches, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule